// File: doc/BRIEF.md
# Concatenable Dual Timer Core

This block holds two counters, A and B, that either run as two separate 16-bit timers with their own 8-bit clock prescalers or act together as one 32-bit timer. Each timer counts down from its load value or up towards it, and either stops after one timeout (one-shot) or reloads and keeps going (periodic). Counting is started and stopped by enable bits, and it can be frozen while a debug-halt input is high when the timer's stall bit is set.

Software-side control arrives through a simple write port (write strobe, 4-bit address, 32-bit data) that stands in for a bus. Each timeout sets a sticky raw flag; a mask selects which flags drive the interrupt output, a write-one-to-clear register drops flags, and an enabled timeout also gives a single-cycle DMA trigger pulse. Counter values, enable state and the flag vectors are visible on output ports.

Top module: `dual_timer_core`

## Requirements
- R1: After reset both counters read 0, both enables and stall bits are 0, the block is in 32-bit mode, and all flags, masks, DMA enables, `irq` and `dma_trig` are 0.
- R2: Address 0 bit 0 selects the width: 0 chains the pair into one 32-bit timer driven only by A's mode (address 1), load (address 4, all 32 bits), enable and stall bits; in that mode counter B never advances, B's mode is ignored and A's prescaler is bypassed. With 1 the halves are independent and A uses only the low 16 bits of its load.
- R3: A mode register (address 1 for A, 2 for B) with bit 1 = 0 counts down: each advance decrements; an advance that finds the counter at 0 is a timeout, after which a periodic timer (bit 0 = 1) reloads its load value.
- R4: With mode bit 1 = 1 the counter counts up from 0; an advance that finds it equal to the load value is a timeout, after which a periodic timer restarts from 0.
- R5: In one-shot mode (mode bit 0 = 0) a timeout leaves the counter at its terminal value and clears that timer's enable bit, seen on `run`, at the same edge.
- R6: In 16-bit mode the prescaler (address 6 for A, 7 for B, 8 bits) makes the counter advance once per P+1 enabled clocks, so a down timer with load L and prescale P times out every (L+1)(P+1) enabled clocks.
- R7: Writing a load register (address 4 or 5) restarts that timer in the next cycle, enabled or not: the counter takes the written value (down) or 0 (up) and the prescaler restarts a full division.
- R8: Control register address 3 holds enable A (bit 0), enable B (bit 1), stall A (bit 2), stall B (bit 3); a disabled timer's counter does not move; writes to addresses 11 to 15 change nothing.
- R9: While `dbg_halt` is high, a timer whose stall bit is set holds its count; one whose stall bit is clear keeps counting.
- R10: A timeout sets raw flag bit 0 (A) or bit 1 (B) on the next edge; the flag stays set; `mask_stat` is the raw flags ANDed with the mask (address 8) and `irq` is high when any masked bit is set.
- R11: Writing to address 9 clears each raw flag whose data bit is 1; a timeout in the same cycle keeps its flag set.
- R12: A timeout whose DMA enable bit (address 10, bit 0 A, bit 1 B) is set raises the matching `dma_trig` bit for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| dbg_halt | input | 1 | Debug halt request |
| value_a | output | 32 | Counter A (full 32-bit count when chained) |
| value_b | output | 16 | Counter B |
| run | output | 2 | Enable bits {B, A} |
| raw_stat | output | 2 | Raw timeout flags {B, A} |
| mask_stat | output | 2 | Masked timeout flags {B, A} |
| irq | output | 1 | Interrupt request |
| dma_trig | output | 2 | Single-cycle DMA trigger {B, A} |

## Verification
On every cycle the assertions check that a timeout of A sets its raw flag, that a set flag survives until a clear write, that a halted stalled or a disabled counter holds its value, that a one-shot timeout drops A's enable, and that a DMA pulse only follows a timeout. Exact counts only show in the bench's scenarios, compared against a behavioural model each cycle: the (L+1)(P+1) period, up-count restart at zero, the borrow across bit 16 when chained, the immediate restart on a load write, and the ignored B mode and bypassed prescaler in 32-bit mode.

// File: rtl/dtmr_pkg.sv
// Shared register selectors and mode type for the dual timer.
package dtmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] SEL_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] SEL_MODE_A = 4'd1;
    localparam logic [ADDR_W-1:0] SEL_MODE_B = 4'd2;
    localparam logic [ADDR_W-1:0] SEL_CTRL   = 4'd3;
    localparam logic [ADDR_W-1:0] SEL_LOAD_A = 4'd4;
    localparam logic [ADDR_W-1:0] SEL_LOAD_B = 4'd5;
    localparam logic [ADDR_W-1:0] SEL_PRE_A  = 4'd6;
    localparam logic [ADDR_W-1:0] SEL_PRE_B  = 4'd7;
    localparam logic [ADDR_W-1:0] SEL_MASK   = 4'd8;
    localparam logic [ADDR_W-1:0] SEL_CLR    = 4'd9;
    localparam logic [ADDR_W-1:0] SEL_DMA    = 4'd10;

    // Mode word: bit 1 = count up, bit 0 = periodic.
    typedef struct packed {
        logic up;
        logic periodic;
    } tmode_t;
endpackage

// File: rtl/dtmr_prescale.sv
// Clock-enable divider for one timer half.
// Assumes: tick is the enabled, not-stalled count clock; when bypass is high
// every tick advances the counter and the internal count is left alone.
module dtmr_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic          bypass,
    input  logic [PW-1:0] div,
    output logic          adv
);
    logic [PW-1:0] cnt_q;

    assign adv = tick && (bypass || (cnt_q == '0));

    // Down-count the division, reloading on wrap or on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= div;
        end else if (tick && !bypass) begin
            cnt_q <= (cnt_q == '0) ? div : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dtmr_count.sv
// Main counter of one timer: counts down to zero or up to the load value.
// Assumes: restart has priority over an advance in the same cycle; tmo is a
// combinational pulse for the advance that hits the terminal value.
module dtmr_count
    import dtmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] seed,
    input  logic         adv,
    input  tmode_t       mode,
    input  logic [W-1:0] load,
    output logic [W-1:0] cnt,
    output logic         tmo
);
    logic [W-1:0] cnt_q;
    logic         at_term;
    logic [W-1:0] start_val;

    assign at_term   = mode.up ? (cnt_q == load) : (cnt_q == '0);
    assign start_val = mode.up ? '0 : load;
    assign tmo       = adv && at_term && !restart;
    assign cnt       = cnt_q;

    // Step, reload or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= mode.up ? '0 : seed;
        end else if (adv) begin
            if (at_term) begin
                if (mode.periodic) begin
                    cnt_q <= start_val;
                end
            end else begin
                cnt_q <= mode.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtmr_irq.sv
// Timeout flags, mask, write-one-to-clear and DMA trigger pulses.
// Assumes: a timeout in the same cycle as a clear keeps its flag set.
module dtmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tmo,
    input  logic         sel_mask,
    input  logic         sel_clr,
    input  logic         sel_dma,
    input  logic [N-1:0] din,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq,
    output logic [N-1:0] dma_trig
);
    logic [N-1:0] mask_q;
    logic [N-1:0] dma_en_q;

    // Hold the mask and DMA enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            dma_en_q <= '0;
        end else begin
            if (sel_mask) mask_q   <= din;
            if (sel_dma)  dma_en_q <= din;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        // Sticky flag with clear and a one-cycle DMA pulse per source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[i]      <= 1'b0;
                dma_trig[i] <= 1'b0;
            end else begin
                raw[i]      <= (raw[i] & ~(sel_clr & din[i])) | tmo[i];
                dma_trig[i] <= tmo[i] & dma_en_q[i];
            end
        end
        assign masked[i] = raw[i] & mask_q[i];
    end

    assign irq = |masked;
endmodule

// File: rtl/dual_timer_core.sv
// Pair of timers that run as two half-width timers or one chained timer.
// Assumes: configuration is written while the timers are disabled; in
// chained mode timer A's counter spans both halves and B stays idle.
module dual_timer_core
    import dtmr_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic                  dbg_halt,
    output logic [2*HALF_W-1:0]   value_a,
    output logic [HALF_W-1:0]     value_b,
    output logic [1:0]            run,
    output logic [1:0]            raw_stat,
    output logic [1:0]            mask_stat,
    output logic                  irq,
    output logic [1:0]            dma_trig
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int NCH    = 2;

    logic              split_q;
    tmode_t            mode_a_q, mode_b_q;
    logic [FULL_W-1:0] load_a_q;
    logic [HALF_W-1:0] load_b_q;
    logic [PRE_W-1:0]  pre_a_q, pre_b_q;
    logic              en_a_q, en_b_q, stall_a_q, stall_b_q;

    logic hit_cfg, hit_mode_a, hit_mode_b, hit_ctrl, hit_load_a, hit_load_b;
    logic hit_pre_a, hit_pre_b, hit_mask, hit_clr, hit_dma;

    logic              tick_a, tick_b, adv_a, adv_b, tmo_a, tmo_b;
    logic [FULL_W-1:0] load_a_eff, seed_a;
    logic [HALF_W-1:0] cnt_b;

    // Decode the write port into one strobe per register.
    always_comb begin
        hit_cfg    = wr_en && (wr_addr == SEL_CFG);
        hit_mode_a = wr_en && (wr_addr == SEL_MODE_A);
        hit_mode_b = wr_en && (wr_addr == SEL_MODE_B);
        hit_ctrl   = wr_en && (wr_addr == SEL_CTRL);
        hit_load_a = wr_en && (wr_addr == SEL_LOAD_A);
        hit_load_b = wr_en && (wr_addr == SEL_LOAD_B);
        hit_pre_a  = wr_en && (wr_addr == SEL_PRE_A);
        hit_pre_b  = wr_en && (wr_addr == SEL_PRE_B);
        hit_mask   = wr_en && (wr_addr == SEL_MASK);
        hit_clr    = wr_en && (wr_addr == SEL_CLR);
        hit_dma    = wr_en && (wr_addr == SEL_DMA);
    end

    // Narrow timer A's load and restart value to one half when split.
    always_comb begin
        if (split_q) begin
            load_a_eff = {{HALF_W{1'b0}}, load_a_q[HALF_W-1:0]};
            seed_a     = {{HALF_W{1'b0}}, wr_data[HALF_W-1:0]};
        end else begin
            load_a_eff = load_a_q;
            seed_a     = wr_data;
        end
    end

    // Gate each count clock with its enable, stall and the width mode.
    always_comb begin
        tick_a = en_a_q && !(stall_a_q && dbg_halt);
        tick_b = split_q && en_b_q && !(stall_b_q && dbg_halt);
    end

    // Configuration registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q   <= 1'b0;
            mode_a_q  <= '0;
            mode_b_q  <= '0;
            load_a_q  <= '0;
            load_b_q  <= '0;
            pre_a_q   <= '0;
            pre_b_q   <= '0;
            stall_a_q <= 1'b0;
            stall_b_q <= 1'b0;
        end else begin
            if (hit_cfg)    split_q  <= wr_data[0];
            if (hit_mode_a) mode_a_q <= tmode_t'(wr_data[1:0]);
            if (hit_mode_b) mode_b_q <= tmode_t'(wr_data[1:0]);
            if (hit_load_a) load_a_q <= wr_data;
            if (hit_load_b) load_b_q <= wr_data[HALF_W-1:0];
            if (hit_pre_a)  pre_a_q  <= wr_data[PRE_W-1:0];
            if (hit_pre_b)  pre_b_q  <= wr_data[PRE_W-1:0];
            if (hit_ctrl) begin
                stall_a_q <= wr_data[2];
                stall_b_q <= wr_data[3];
            end
        end
    end

    // Enable bits: set by software, dropped by a one-shot timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a_q <= 1'b0;
            en_b_q <= 1'b0;
        end else if (hit_ctrl) begin
            en_a_q <= wr_data[0];
            en_b_q <= wr_data[1];
        end else begin
            if (tmo_a && !mode_a_q.periodic) en_a_q <= 1'b0;
            if (tmo_b && !mode_b_q.periodic) en_b_q <= 1'b0;
        end
    end

    dtmr_prescale #(.PW(PRE_W)) u_pre_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit_load_a),
        .tick    (tick_a),
        .bypass  (!split_q),
        .div     (pre_a_q),
        .adv     (adv_a)
    );

    dtmr_prescale #(.PW(PRE_W)) u_pre_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit_load_b),
        .tick    (tick_b),
        .bypass  (!split_q),
        .div     (pre_b_q),
        .adv     (adv_b)
    );

    dtmr_count #(.W(FULL_W)) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit_load_a),
        .seed    (seed_a),
        .adv     (adv_a),
        .mode    (mode_a_q),
        .load    (load_a_eff),
        .cnt     (value_a),
        .tmo     (tmo_a)
    );

    dtmr_count #(.W(HALF_W)) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit_load_b),
        .seed    (wr_data[HALF_W-1:0]),
        .adv     (adv_b),
        .mode    (mode_b_q),
        .load    (load_b_q),
        .cnt     (cnt_b),
        .tmo     (tmo_b)
    );

    dtmr_irq #(.N(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo      ({tmo_b, tmo_a}),
        .sel_mask (hit_mask),
        .sel_clr  (hit_clr),
        .sel_dma  (hit_dma),
        .din      (wr_data[NCH-1:0]),
        .raw      (raw_stat),
        .masked   (mask_stat),
        .irq      (irq),
        .dma_trig (dma_trig)
    );

    assign value_b = cnt_b;
    assign run     = {en_b_q, en_a_q};
endmodule

// File: rtl/dtmr_chk.sv
// Temporal checks on timer A, attached to the core by bind.
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [2*HALF_W-1:0] wr_data,
    input logic                dbg_halt,
    input logic [2*HALF_W-1:0] value_a,
    input logic [1:0]          run,
    input logic [1:0]          raw_stat,
    input logic [1:0]          dma_trig,
    input logic                tmo_a,
    input logic                stall_a,
    input logic                periodic_a
);
    logic load_wr_a;
    assign load_wr_a = wr_en && (wr_addr == SEL_LOAD_A);

    // R10
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_a |=> raw_stat[0]);

    // R11
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[0] && !(wr_en && (wr_addr == SEL_CLR) && wr_data[0])) |=> raw_stat[0]);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && stall_a && dbg_halt && !load_wr_a) |=> $stable(value_a));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[0] && !load_wr_a) |=> $stable(value_a));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_a && !periodic_a && !(wr_en && (wr_addr == SEL_CTRL))) |=> !run[0]);

    // R12
    dma_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_trig[0] |-> $past(tmo_a));
endmodule

bind dual_timer_core dtmr_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dbg_halt   (dbg_halt),
    .value_a    (value_a),
    .run        (run),
    .raw_stat   (raw_stat),
    .dma_trig   (dma_trig),
    .tmo_a      (tmo_a),
    .stall_a    (stall_a_q),
    .periodic_a (mode_a_q.periodic)
);

// File: tb/dual_timer_core_tb_top.sv
module dual_timer_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic        dbg_halt;
    logic [31:0] value_a;
    logic [15:0] value_b;
    logic [1:0]  run, raw_stat, mask_stat, dma_trig;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    dual_timer_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dbg_halt(dbg_halt), .value_a(value_a),
        .value_b(value_b), .run(run), .raw_stat(raw_stat),
        .mask_stat(mask_stat), .irq(irq), .dma_trig(dma_trig)
    );

    // Behavioural reference state.
    logic        m_split;
    logic [1:0]  m_per, m_up, m_en, m_stall, m_raw, m_mask, m_dmaen, m_dma;
    logic [31:0] m_la, m_ca, lea;
    logic [15:0] m_lb, m_cb;
    logic [7:0]  m_pa, m_pb, m_qa, m_qb;
    logic        ta, tb, aa, ab, ra, rb, terma, termb, toa, tob;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_split = 0; m_per = 0; m_up = 0; m_en = 0; m_stall = 0;
            m_raw = 0; m_mask = 0; m_dmaen = 0; m_dma = 0;
            m_la = 0; m_ca = 0; m_lb = 0; m_cb = 0;
            m_pa = 0; m_pb = 0; m_qa = 0; m_qb = 0;
        end else begin
            ra = wr_en && wr_addr == 4;
            rb = wr_en && wr_addr == 5;
            ta = m_en[0] && !(m_stall[0] && dbg_halt);
            tb = m_split && m_en[1] && !(m_stall[1] && dbg_halt);
            aa = ta && (!m_split || m_qa == 0);
            ab = tb && (m_qb == 0);
            lea = m_split ? {16'h0, m_la[15:0]} : m_la;
            terma = m_up[0] ? (m_ca == lea) : (m_ca == 0);
            termb = m_up[1] ? (m_cb == m_lb) : (m_cb == 0);
            toa = aa && !ra && terma;
            tob = ab && !rb && termb;
            if (ra) m_qa = m_pa;
            else if (ta && m_split) m_qa = (m_qa == 0) ? m_pa : m_qa - 8'd1;
            if (rb) m_qb = m_pb;
            else if (tb) m_qb = (m_qb == 0) ? m_pb : m_qb - 8'd1;
            if (ra) m_ca = m_up[0] ? 32'h0 : (m_split ? {16'h0, wr_data[15:0]} : wr_data);
            else if (aa) begin
                if (terma) begin if (m_per[0]) m_ca = m_up[0] ? 32'h0 : lea; end
                else m_ca = m_up[0] ? m_ca + 32'd1 : m_ca - 32'd1;
            end
            if (rb) m_cb = m_up[1] ? 16'h0 : wr_data[15:0];
            else if (ab) begin
                if (termb) begin if (m_per[1]) m_cb = m_up[1] ? 16'h0 : m_lb; end
                else m_cb = m_up[1] ? m_cb + 16'd1 : m_cb - 16'd1;
            end
            m_dma = {tob, toa} & m_dmaen;
            m_raw = (m_raw & ~((wr_en && wr_addr == 9) ? wr_data[1:0] : 2'b00)) | {tob, toa};
            if (wr_en && wr_addr == 3) begin
                m_en = wr_data[1:0];
                m_stall = wr_data[3:2];
            end else begin
                if (toa && !m_per[0]) m_en[0] = 1'b0;
                if (tob && !m_per[1]) m_en[1] = 1'b0;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_split = wr_data[0];
                    4'd1: begin m_per[0] = wr_data[0]; m_up[0] = wr_data[1]; end
                    4'd2: begin m_per[1] = wr_data[0]; m_up[1] = wr_data[1]; end
                    4'd4: m_la = wr_data;
                    4'd5: m_lb = wr_data[15:0];
                    4'd6: m_pa = wr_data[7:0];
                    4'd7: m_pb = wr_data[7:0];
                    4'd8: m_mask = wr_data[1:0];
                    4'd10: m_dmaen = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        cyc++;
        cmp("value_a", value_a, m_ca);
        cmp("value_b", {16'h0, value_b}, {16'h0, m_cb});
        cmp("run", {30'h0, run}, {30'h0, m_en});
        cmp("raw_stat", {30'h0, raw_stat}, {30'h0, m_raw});
        cmp("mask_stat", {30'h0, mask_stat}, {30'h0, m_raw & m_mask});
        cmp("irq", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
        cmp("dma_trig", {30'h0, dma_trig}, {30'h0, m_dma});
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_addr = 4'd15; wr_data = 32'h0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 4'd15; wr_data = 32'h0; dbg_halt = 1'b0;
        step(3);
        rst_n = 1'b1;
        // R1: explicit reset values
        cmp("reset value_a", value_a, 32'h0);
        cmp("reset raw", {30'h0, raw_stat}, 32'h0);

        // R3: split, down, periodic, no prescale; R10 and R12 with mask and DMA on
        cur_req = "R3";
        wr(4'd0, 32'h1); wr(4'd1, 32'h1); wr(4'd6, 32'h0); wr(4'd4, 32'h3);
        wr(4'd8, 32'h3); wr(4'd10, 32'h3); wr(4'd3, 32'h1);
        step(12);
        // R11: clear, then clear while timeouts keep coming
        cur_req = "R11";
        wr(4'd9, 32'h1); step(2); wr(4'd9, 32'h3); step(3);
        // R6: prescaler divides in split mode
        cur_req = "R6";
        wr(4'd3, 32'h0); wr(4'd6, 32'h2); wr(4'd4, 32'h2); wr(4'd3, 32'h1);
        step(24);
        // R4: B counts up, periodic, prescale 1
        cur_req = "R4";
        wr(4'd3, 32'h0); wr(4'd9, 32'h3); wr(4'd2, 32'h3); wr(4'd5, 32'h4);
        wr(4'd7, 32'h1); wr(4'd3, 32'h2);
        step(22);
        // R5: A one-shot down stops and clears its enable
        cur_req = "R5";
        wr(4'd3, 32'h0); wr(4'd1, 32'h0); wr(4'd6, 32'h0); wr(4'd4, 32'h5);
        wr(4'd3, 32'h1);
        step(10);
        // R9: stall with and without the stall bit
        cur_req = "R9";
        wr(4'd1, 32'h1); wr(4'd4, 32'h6); wr(4'd3, 32'h5);
        dbg_halt = 1'b1; step(5); dbg_halt = 1'b0; step(3);
        wr(4'd3, 32'h1); dbg_halt = 1'b1; step(5); dbg_halt = 1'b0;
        // R7: load writes restart a running timer
        cur_req = "R7";
        step(2); wr(4'd4, 32'h9); step(3); wr(4'd4, 32'h2); step(5);
        wr(4'd1, 32'h3); wr(4'd4, 32'h7); step(4);
        // R2: chained 32-bit mode, B mode and A prescaler ignored
        cur_req = "R2";
        wr(4'd3, 32'h0); wr(4'd0, 32'h0); wr(4'd1, 32'h1); wr(4'd6, 32'h5);
        wr(4'd2, 32'h3); wr(4'd4, 32'h0001_0002); wr(4'd3, 32'h3);
        step(10);
        wr(4'd4, 32'h2); step(8);
        // R8: disable freezes; unused address ignored
        cur_req = "R8";
        wr(4'd3, 32'h0); step(4); wr(4'd15, 32'hFFFF_FFFF); wr(4'd11, 32'h3); step(3);
        // R10: masked off flags do not reach irq
        cur_req = "R10";
        wr(4'd9, 32'h3); wr(4'd8, 32'h0); wr(4'd3, 32'h1); step(6);
        wr(4'd8, 32'h1); step(2);
        // R12: DMA only for A
        cur_req = "R12";
        wr(4'd10, 32'h1); step(8); wr(4'd10, 32'h0); step(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule